// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive request lines and presents one of them at a time to a processor. Each source has an entry in a vector table that software fills in. When a source is both requesting and enabled, and no earlier service is still open, the controller captures that source's number and its table entry, then raises a line toward the processor. A normal source raises the IRQ line. The one source chosen as fast raises the FIQ line instead.

Software acknowledges the interrupt by reading registers. Reading the captured vector drops the processor line. Reading the captured source number returns it once and then sets it back to zero. A write to the end-of-interrupt command closes the open service, and the next pending enabled source can then be taken. When several sources request at the same time, the source with the lowest number is taken first.

The register port is a word-addressed strobe interface. A read strobe loads the read-data register at the next clock edge. Read side effects take place at that same edge.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A write to word offset 0 (enable-set) ORs the written data into the enable mask. A read of offset 0 or offset 1 returns the mask.
- R2: A write to word offset 1 (enable-clear) clears, in the enable mask, every bit that is 1 in the written data. A source whose mask bit is clear is never serviced.
- R3: A source is serviced only when its request is high and its mask bit is set. Servicing loads the status register (offset 3) with the source number and loads the vector register (offset 2) from that source's table entry.
- R4: When several enabled sources are pending at once, the lowest-numbered source is serviced.
- R5: Servicing a source raises processor line index 0 (IRQ) in the following cycle. The exception is source FIQ_SRC (default 0), which raises line index 1 (FIQ) instead. The two lines are never high together.
- R6: A read of offset 2 returns the latched vector. It drops both processor lines at the same edge that loads the read data.
- R7: A read of offset 3 returns the latched source number, and the status register then holds zero.
- R8: A write to offset 2 is ignored. A write to offset 4 (end-of-interrupt) leaves the mask, the status register and the vector register unchanged.
- R9: No new source is latched while a service is open, or while a processor line is high. After the end-of-interrupt write, the next pending enabled source is serviced on the following edge.
- R10: After reset the mask, the status register, the vector register and every table entry are zero, and both processor lines are low.
- R11: Word offset 32+n reads and writes table entry n, for n from 0 to 31.
- R12: Read data appears in the cycle after the read strobe. A read of an unmapped offset (5 to 31) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcReq | input | 32 | Level request per source |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busAddr | input | 6 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRd |
| cpuLine | output | 2 | Processor lines: index 0 IRQ, index 1 FIQ |

## Verification
The bench builds the block with its defaults: 32 sources, 32-bit data and source 0 as the fast source. With these settings every table entry is addressable, including the highest offset. Source 0 can be used both as the FIQ case and as a zero status value, which makes the read-to-clear ambiguity visible. Sources 5 and 9 requesting together exercise the priority choice, and holding source 5 high while a service is open exercises the blocking rule.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASK,
    RD_VEC,
    RD_STAT,
    RD_TBL
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   setMask;
    logic   clrMask;
    logic   tblWr;
    logic   latch;
    logic   clrStat;
    logic   rdEn;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/vec_irq_ctrl_fsm.sv
module vec_irq_ctrl_fsm
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              pendAny,
  input  logic              pendIsFast,
  output ctrlStrobe_t       ctrlS,
  output logic              irqOut,
  output logic              fiqOut
);

  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(4);

  logic busy;
  logic tblHit;
  logic eoiWr;
  logic vecRd;

  assign tblHit = busAddr[ADDR_W-1];
  assign eoiWr  = busWr && (busAddr == A_EOI);
  assign vecRd  = busRd && (busAddr == A_VEC);

  always_comb begin
    ctrlS         = '0;
    ctrlS.rdSel   = RD_NONE;
    ctrlS.setMask = busWr && (busAddr == A_SET);
    ctrlS.clrMask = busWr && (busAddr == A_CLR);
    ctrlS.tblWr   = busWr && tblHit;
    ctrlS.clrStat = busRd && (busAddr == A_STAT);
    ctrlS.latch   = !busy && !irqOut && !fiqOut && pendAny;
    ctrlS.rdEn    = busRd;
    if (tblHit)                                   ctrlS.rdSel = RD_TBL;
    else if (busAddr == A_SET || busAddr == A_CLR) ctrlS.rdSel = RD_MASK;
    else if (busAddr == A_VEC)                    ctrlS.rdSel = RD_VEC;
    else if (busAddr == A_STAT)                   ctrlS.rdSel = RD_STAT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      if (ctrlS.latch) begin
        busy   <= 1'b1;
        irqOut <= !pendIsFast;
        fiqOut <= pendIsFast;
      end else begin
        if (eoiWr) busy <= 1'b0;
        if (vecRd) begin
          irqOut <= 1'b0;
          fiqOut <= 1'b0;
        end
      end
    end
  end

  AST_LINE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && fiqOut)); // R5

  AST_VEC_RD_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && busy) |=> (!irqOut && !fiqOut)); // R6

  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !eoiWr) |=> busy); // R9

endmodule

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int FIQ_SRC = 0,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctrlS,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               pendAny,
  output logic               pendIsFast
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] pendVec;
  logic [DATA_W-1:0]  vecTable [NUM_SRC];
  logic [IDX_W-1:0]   statReg;
  logic [DATA_W-1:0]  vecReg;
  logic [IDX_W-1:0]   pendIdx;
  logic [IDX_W-1:0]   tblIdx;
  logic [DATA_W-1:0]  wMask;

  assign pendVec    = srcReq & enMask;
  assign pendAny    = |pendVec;
  assign pendIsFast = (pendIdx == IDX_W'(FIQ_SRC));
  assign tblIdx     = busAddr[IDX_W-1:0];
  assign wMask      = busWdata;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    pendIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) pendIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
    end else if (ctrlS.setMask) begin
      enMask <= enMask | wMask[NUM_SRC-1:0];
    end else if (ctrlS.clrMask) begin
      enMask <= enMask & ~wMask[NUM_SRC-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gTbl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vecTable[g] <= '0;
      end else if (ctrlS.tblWr && tblIdx == IDX_W'(g)) begin
        vecTable[g] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statReg <= '0;
      vecReg  <= '0;
    end else if (ctrlS.latch) begin
      statReg <= pendIdx;
      vecReg  <= vecTable[pendIdx];
    end else if (ctrlS.clrStat) begin
      statReg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (ctrlS.rdEn) begin
      case (ctrlS.rdSel)
        RD_MASK: busRdata <= DATA_W'(enMask);
        RD_VEC:  busRdata <= vecReg;
        RD_STAT: busRdata <= DATA_W'(statReg);
        RD_TBL:  busRdata <= vecTable[tblIdx];
        default: busRdata <= '0;
      endcase
    end
  end

  AST_MASK_OR: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.setMask |=> ((enMask & $past(wMask[NUM_SRC-1:0])) == $past(wMask[NUM_SRC-1:0]))); // R1

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.clrMask |=> ((enMask & $past(wMask[NUM_SRC-1:0])) == '0)); // R2

  AST_LATCH_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.latch |-> ((srcReq & enMask) != '0)); // R3

  AST_STAT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlS.clrStat && !ctrlS.latch) |=> (statReg == '0)); // R7

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int FIQ_SRC = 0,
  parameter int ADDR_W  = $clog2(NUM_SRC) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [1:0]         cpuLine
);

  ctrlStrobe_t ctrlS;
  logic pendAny;
  logic pendIsFast;
  logic irqOut;
  logic fiqOut;

  vec_irq_ctrl_fsm #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .pendAny(pendAny), .pendIsFast(pendIsFast),
    .ctrlS(ctrlS), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  vec_irq_datapath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .FIQ_SRC(FIQ_SRC), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrlS(ctrlS), .srcReq(srcReq),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pendAny(pendAny), .pendIsFast(pendIsFast)
  );

  assign cpuLine = {fiqOut, irqOut};

endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;

  localparam int NS = 32;
  localparam int DW = 32;
  localparam int AW = 6;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcReq = '0;
  logic          busRd = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [1:0]    cpuLine;

  int nApplied = 0;
  int nMiss = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .cpuLine(cpuLine)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    busWr = 1'b1; busAddr = AW'(a); busWdata = d;
    tick();
    busWr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
    expItem_t it;
    it.val = e; it.tag = tag;
    expQ.push_back(it);
    busRd = 1'b1; busAddr = AW'(a);
    tick();
    busRd = 1'b0;
  endtask

  task automatic checkLine(input logic irq, input logic fiq, input string tag);
    nApplied++;
    if (cpuLine !== {fiq, irq}) begin
      nMiss++;
      $display("FAIL %s: cpuLine actual %b expected %b", tag, cpuLine, {fiq, irq});
    end
  endtask

  // monitor: compares read data one edge after each read strobe
  always @(posedge clk) begin
    if (busRd) begin
      #2;
      if (expQ.size() == 0) begin
        nApplied++; nMiss++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        nApplied++;
        if (busRdata !== it.val) begin
          nMiss++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, busRdata, it.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nMiss++;
    $display("FAIL watchdog: run did not end, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nMiss);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R10 reset state
    checkLine(1'b0, 1'b0, "R10");
    rd(0, 0, "R10 mask");
    rd(3, 0, "R10 status");
    rd(2, 0, "R10 vector");
    rd(32 + 31, 0, "R10 table");
    // R11 fill the table
    for (int n = 0; n < NS; n++) wr(32 + n, 32'h1000 + n * 4);
    rd(32 + 5, 32'h1014, "R11 entry5");
    rd(32 + 31, 32'h107C, "R11 entry31");
    // R3 pending but masked
    srcReq = 32'h1 << 5;
    tick(); tick();
    checkLine(1'b0, 1'b0, "R3 masked");
    rd(3, 0, "R3 masked status");
    // R1 enable 5 and 9, service of 5 follows
    wr(0, 32'h220);
    rd(0, 32'h220, "R1 mask");
    checkLine(1'b1, 1'b0, "R5 irq");
    rd(3, 5, "R3 status");
    rd(3, 0, "R7 cleared");
    rd(2, 32'h1014, "R6 vector");
    checkLine(1'b0, 1'b0, "R6 drop");
    tick(); tick(); tick();
    checkLine(1'b0, 1'b0, "R9 blocked");
    // close, then two sources at once
    srcReq = '0;
    wr(4, 0);
    tick();
    checkLine(1'b0, 1'b0, "R9 idle");
    srcReq = (32'h1 << 9) | (32'h1 << 5);
    tick();
    checkLine(1'b1, 1'b0, "R4 irq");
    rd(3, 5, "R4 lowest");
    rd(2, 32'h1014, "R4 vector");
    srcReq = 32'h1 << 9;
    wr(4, 0);
    tick();
    checkLine(1'b1, 1'b0, "R9 next");
    srcReq = '0;
    rd(2, 32'h1024, "R9 vector9");
    wr(4, 0);
    wr(2, 32'hDEAD_BEEF);
    rd(2, 32'h1024, "R8 vec write");
    rd(3, 9, "R8 eoi status");
    rd(0, 32'h220, "R8 eoi mask");
    // R2 disable source 5
    wr(1, 32'h1 << 5);
    rd(1, 32'h200, "R2 mask");
    srcReq = 32'h1 << 5;
    tick(); tick();
    checkLine(1'b0, 1'b0, "R2 disabled");
    wr(32 + 7, 32'hCAFE_0007);
    rd(32 + 7, 32'hCAFE_0007, "R11 rewrite");
    // R5 fast source
    srcReq = 32'h1 | (32'h1 << 5);
    wr(0, 32'h1);
    tick();
    checkLine(1'b0, 1'b1, "R5 fiq");
    rd(2, 32'h1000, "R5 vector0");
    checkLine(1'b0, 1'b0, "R6 fiq drop");
    srcReq = '0;
    wr(4, 0);
    rd(5, 0, "R12 unmapped");
    rd(31, 0, "R12 unmapped top");
    tick(); tick();
    if (expQ.size() != 0) begin
      nApplied++; nMiss++;
      $display("FAIL R12: %0d reads unanswered, expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nMiss);
    $finish;
  end

endmodule